// File: doc/BRIEF.md
# Scannable Octal Transparent Latch

An eight-bit transparent latch wrapped in an 18-cell boundary register. In normal mode the latch passes its data inputs through while the latch enable is high. It keeps the last passed value while the enable is low. An active-low output enable drops the output drive flag, which stands in for a high-impedance pad. A test controller outside this block can sample every pin into the boundary register, shift the register serially, and move its contents into a separate update stage, all without disturbing the latch.

When test mode is raised, the latch stops accepting data. The output data and the output drive flag are then taken from the update stage of the boundary cells. The controller supplies one-cycle strobes for capture, shift and update. Capture and shift act on the rising edge of the test clock. Update acts on the falling edge.

Top module: `scan_latch8_bnd`

## Requirements
- R1: In normal mode (`test_mode` low), `oe_n_in` high forces `q_oe` low, whatever `le_in` and `d_in` are doing.
- R2: In normal mode with `oe_n_in` low and `le_in` high, `q_out` equals `d_in` and `q_oe` is high.
- R3: In normal mode with `le_in` low, `q_out` keeps the value `d_in` had when `le_in` fell.
- R4: On a rising clock edge with `capture_en` high, the shift stage loads 18 bits: bits 7..0 take `d_in`, bit 8 takes `le_in`, bit 9 takes `oe_n_in`, and bits 17..10 take the data value on `q_out`. Capture takes priority over shift.
- R5: On a rising clock edge with `shift_en` high (and `capture_en` low), `tdi` enters bit 17 and every bit moves one place toward bit 0. `tdo` shows bit 0 of the shift stage.
- R6: On a falling clock edge with `update_en` high, the update stage copies the shift stage. Otherwise the update stage holds, so the outputs do not move while data shifts.
- R7: In test mode, `q_out` equals update bits 17..10 and `q_oe` is the inverse of update bit 9.
- R8: While `test_mode` is high, the latch ignores `le_in` and `d_in`. On return to normal mode with `le_in` low, `q_out` shows the value held before test mode.
- R9: In normal mode, capture, shift and update leave `q_out` and `q_oe` unchanged.
- R10: A low `rst_n` clears the shift and update stages at once. The internal reset is released on the second rising edge after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_mode | input | 1 | 1: boundary cells drive the outputs |
| d_in | input | 8 | Latch data inputs |
| le_in | input | 1 | Latch enable, high = transparent |
| oe_n_in | input | 1 | Output enable, active low |
| q_out | output | 8 | Output data value |
| q_oe | output | 1 | 1: outputs driven, 0: high-impedance |
| tdi | input | 1 | Serial scan input |
| capture_en | input | 1 | Load pin values into the shift stage |
| shift_en | input | 1 | Shift the register one place |
| update_en | input | 1 | Copy the shift stage to the update stage |
| tdo | output | 1 | Serial scan output |

## Verification
Two situations are the hardest to reach from the ports. The first is a latch value that must survive a test-mode session while `le_in` is high and `d_in` is moving. The stimulus first holds a known byte in normal mode. It then toggles the data with the enable high for several test-mode cycles, drops the enable, and leaves test mode. The second is output stability in the middle of a shift. The scan task samples `q_out` halfway through an 18-bit shift and compares it with the previously updated value.

// File: rtl/scanlat_pkg.sv
package scanlat_pkg;
  localparam int unsigned LAT_W_DEF = 8;
  localparam int unsigned CTRL_CELLS = 2;

  function automatic int unsigned cell_count(input int unsigned w);
    return 2 * w + CTRL_CELLS;
  endfunction
endpackage

// File: rtl/scanlat_rst_sync.sv
module scanlat_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic stg1_q;
  logic stg2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= 1'b0;
      stg2_q <= 1'b0;
    end else begin
      stg1_q <= 1'b1;
      stg2_q <= stg1_q;
    end
  end

  assign rst_s_n = stg2_q;
endmodule

// File: rtl/scanlat_cell.sv
module scanlat_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_en,
  input  logic shf_en,
  input  logic upd_en,
  input  logic cap_in,
  input  logic scan_in,
  output logic shf_q,
  output logic upd_q
);
  logic shf_d;
  logic upd_d;

  always_comb begin
    shf_d = shf_q;
    if (cap_en)      shf_d = cap_in;
    else if (shf_en) shf_d = scan_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shf_q <= 1'b0;
    else        shf_q <= shf_d;
  end

  always_comb begin
    upd_d = upd_q;
    if (upd_en) upd_d = shf_q;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) upd_q <= 1'b0;
    else        upd_q <= upd_d;
  end
endmodule

// File: rtl/scanlat_latch.sv
module scanlat_latch #(
  parameter int unsigned W = 8
) (
  input  logic         gate,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_latch begin
    if (gate) q <= d;
  end
endmodule

// File: rtl/scan_latch8_bnd.sv
module scan_latch8_bnd #(
  parameter int unsigned W = scanlat_pkg::LAT_W_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         test_mode,
  input  logic [W-1:0] d_in,
  input  logic         le_in,
  input  logic         oe_n_in,
  output logic [W-1:0] q_out,
  output logic         q_oe,
  input  logic         tdi,
  input  logic         capture_en,
  input  logic         shift_en,
  input  logic         update_en,
  output logic         tdo
);
  localparam int unsigned N      = scanlat_pkg::cell_count(W);
  localparam int unsigned IDX_LE = W;
  localparam int unsigned IDX_OE = W + 1;
  localparam int unsigned OUT_LO = W + 2;

  logic         rst_s_n;
  logic [N-1:0] cap_vec;
  logic [N-1:0] sr;
  logic [N-1:0] upd;
  logic [W-1:0] lat_q;
  logic         lat_gate;

  scanlat_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  assign lat_gate = le_in & ~test_mode;

  scanlat_latch #(.W(W)) u_lat (
    .gate (lat_gate),
    .d    (d_in),
    .q    (lat_q)
  );

  always_comb begin
    if (test_mode) begin
      q_out = upd[N-1:OUT_LO];
      q_oe  = ~upd[IDX_OE];
    end else begin
      q_out = lat_q;
      q_oe  = ~oe_n_in;
    end
  end

  assign cap_vec = {q_out, oe_n_in, le_in, d_in};

  for (genvar k = 0; k < N; k++) begin : g_cell
    logic sin;
    if (k == N - 1) begin : g_head
      assign sin = tdi;
    end else begin : g_link
      assign sin = sr[k+1];
    end
    scanlat_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_s_n),
      .cap_en  (capture_en),
      .shf_en  (shift_en),
      .upd_en  (update_en),
      .cap_in  (cap_vec[k]),
      .scan_in (sin),
      .shf_q   (sr[k]),
      .upd_q   (upd[k])
    );
  end

  assign tdo = sr[0];

  logic unused_le_idx;
  assign unused_le_idx = (IDX_LE == 0);
endmodule

// File: rtl/scanlat_chk.sv
module scanlat_chk #(
  parameter int unsigned W = 8,
  parameter int unsigned N = 2 * W + 2
) (
  input logic         clk,
  input logic         rst_s_n,
  input logic         test_mode,
  input logic [W-1:0] d_in,
  input logic         le_in,
  input logic         oe_n_in,
  input logic [W-1:0] q_out,
  input logic         q_oe,
  input logic         tdi,
  input logic         capture_en,
  input logic         shift_en,
  input logic         update_en,
  input logic [N-1:0] sr,
  input logic [N-1:0] upd
);
  AST_HIZ_WHEN_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!test_mode && oe_n_in) |-> !q_oe); // R1

  AST_TRANSPARENT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!test_mode && !oe_n_in && le_in) |-> (q_out == d_in && q_oe)); // R2

  AST_CAPTURE_PINS: assert property (@(posedge clk) disable iff (!rst_s_n)
    capture_en |=> (sr == $past({q_out, oe_n_in, le_in, d_in}))); // R4

  AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!rst_s_n)
    (shift_en && !capture_en) |=> (sr == {$past(tdi), $past(sr[N-1:1])})); // R5

  AST_UPDATE_HOLD: assert property (@(negedge clk) disable iff (!rst_s_n)
    !update_en |=> $stable(upd)); // R6

  AST_TEST_DRIVE: assert property (@(posedge clk) disable iff (!rst_s_n)
    test_mode |-> (q_out == upd[N-1:W+2] && q_oe == !upd[W+1])); // R7
endmodule

bind scan_latch8_bnd scanlat_chk #(.W(W), .N(N)) u_chk (
  .clk        (clk),
  .rst_s_n    (rst_s_n),
  .test_mode  (test_mode),
  .d_in       (d_in),
  .le_in      (le_in),
  .oe_n_in    (oe_n_in),
  .q_out      (q_out),
  .q_oe       (q_oe),
  .tdi        (tdi),
  .capture_en (capture_en),
  .shift_en   (shift_en),
  .update_en  (update_en),
  .sr         (sr),
  .upd        (upd)
);

// File: tb/scan_latch8_bnd_tb.sv
module scan_latch8_bnd_tb;
  localparam int W = 8;
  localparam int N = 2 * W + 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst_n;
  logic         test_mode;
  logic [W-1:0] d_in;
  logic         le_in;
  logic         oe_n_in;
  logic [W-1:0] q_out;
  logic         q_oe;
  logic         tdi;
  logic         capture_en;
  logic         shift_en;
  logic         update_en;
  logic         tdo;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [W-1:0] mid_q;
  logic [N-1:0] got;

  scan_latch8_bnd #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .d_in(d_in),
    .le_in(le_in), .oe_n_in(oe_n_in), .q_out(q_out), .q_oe(q_oe),
    .tdi(tdi), .capture_en(capture_en), .shift_en(shift_en),
    .update_en(update_en), .tdo(tdo)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic scan(input logic [N-1:0] vin, input bit cap, input bit upd,
                      output logic [N-1:0] vout);
    if (cap) begin
      capture_en = 1'b1;
      step();
      capture_en = 1'b0;
    end
    shift_en = 1'b1;
    for (int i = 0; i < N; i++) begin
      tdi = vin[i];
      #2;
      vout[i] = tdo;
      if (i == N / 2) mid_q = q_out;
      step();
    end
    shift_en = 1'b0;
    if (upd) begin
      update_en = 1'b1;
      @(negedge clk);
      #1;
      update_en = 1'b0;
    end
    step();
  endtask

  task automatic t_reset();
    chk("R10 tdo after reset", {31'd0, tdo}, 32'd0);
    test_mode = 1'b1;
    #2;
    chk("R10 update stage data clear", {24'd0, q_out}, 32'd0);
    chk("R10 update oe cell clear", {31'd0, q_oe}, 32'd1);
    test_mode = 1'b0;
    step();
  endtask

  task automatic t_shift();
    logic [N-1:0] pat = 18'h2D4B3;
    scan(pat, 1'b0, 1'b0, got);
    chk("R10 shift stage clear", {14'd0, got}, 32'd0);
    scan('0, 1'b0, 1'b0, got);
    chk("R5 shift-through order", {14'd0, got}, {14'd0, pat});
  endtask

  task automatic t_normal();
    oe_n_in = 1'b0; le_in = 1'b1; d_in = 8'hA5;
    #2;
    chk("R2 follow data", {24'd0, q_out}, 32'hA5);
    chk("R2 driven", {31'd0, q_oe}, 32'd1);
    step();
    le_in = 1'b0; #1; d_in = 8'h3C;
    #2;
    chk("R3 hold after le fall", {24'd0, q_out}, 32'hA5);
    step();
    oe_n_in = 1'b1; #2;
    chk("R1 hiz with oe high", {31'd0, q_oe}, 32'd0);
    step();
    le_in = 1'b1; d_in = 8'h0F; #2;
    chk("R1 hiz while le and data move", {31'd0, q_oe}, 32'd0);
    step();
    oe_n_in = 1'b0; #2;
    chk("R2 value loaded during hiz", {24'd0, q_out}, 32'h0F);
    step();
    le_in = 1'b0; step();
    d_in = 8'hC3; step();
  endtask

  task automatic t_capture_normal();
    logic [N-1:0] pat = {8'h96, 1'b0, 1'b1, 8'h55};
    scan(pat, 1'b1, 1'b1, got);
    chk("R4 capture in normal mode", {14'd0, got}, {14'd0, 8'h0F, 1'b0, 1'b0, 8'hC3});
    chk("R9 q stable mid-shift", {24'd0, mid_q}, 32'h0F);
    chk("R9 q after update", {24'd0, q_out}, 32'h0F);
    chk("R9 oe after update", {31'd0, q_oe}, 32'd1);
  endtask

  task automatic t_test_mode();
    logic [N-1:0] pat = {8'h3E, 1'b1, 1'b0, 8'h00};
    test_mode = 1'b1; #2;
    chk("R7 test data from update", {24'd0, q_out}, 32'h96);
    chk("R7 test oe from update", {31'd0, q_oe}, 32'd1);
    step();
    scan(pat, 1'b1, 1'b1, got);
    chk("R4 capture in test mode", {14'd0, got}, {14'd0, 8'h96, 1'b0, 1'b0, 8'hC3});
    chk("R6 no ripple mid-shift", {24'd0, mid_q}, 32'h96);
    chk("R7 new data after update", {24'd0, q_out}, 32'h3E);
    chk("R7 oe cell high disables", {31'd0, q_oe}, 32'd0);
  endtask

  task automatic t_inhibit();
    le_in = 1'b1; d_in = 8'hEE; step();
    d_in = 8'h71; step();
    le_in = 1'b0; step();
    test_mode = 1'b0; #2;
    chk("R8 latch kept pre-test value", {24'd0, q_out}, 32'h0F);
    step();
    le_in = 1'b1; #2;
    chk("R2 follow after test mode", {24'd0, q_out}, 32'h71);
    step();
  endtask

  initial begin
    rst_n = 1'b0; test_mode = 1'b0; d_in = '0; le_in = 1'b0; oe_n_in = 1'b1;
    tdi = 1'b0; capture_en = 1'b0; shift_en = 1'b0; update_en = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();
    t_reset();
    t_shift();
    t_normal();
    t_capture_normal();
    t_test_mode();
    t_inhibit();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule